// File: doc/BRIEF.md
# Speed-Loop PI Duty-Cycle Generator

This block closes the digital speed loop of a motor drive whose DC link is supplied by a DC-DC front stage. On every sample strobe it takes a commanded speed and a measured rotor speed, both signed integers. It subtracts them and turns the speed difference into an equivalent voltage error, using a fixed-point ratio of converter full-scale voltage to rated speed.

An incremental proportional-integral law updates a control word from that error. The proportional part acts on the change in error. The integral part uses the trapezoid of the current and previous errors, already multiplied by the sampling interval. The new word is clamped to the usable duty range, and that clamped value is what the next update starts from.

A symmetric up/down triangle carrier, sized from the system clock to a 20 kHz period, is compared against the control word. The result is the single gate signal for the converter switch. The compare value is taken over only at the carrier valley, so every carrier period uses one duty value.

Top module: `speed_pi_pwm`

## Requirements
- R1: During and after reset, and before any sample strobe, the gate output stays low for a whole carrier period.
- R2: On a strobe the speed error is refSpeed minus actSpeed. The voltage error is that difference times SCALE_Q, divided by 2^SCALE_FRAC and rounded half up.
- R3: On a strobe the control word becomes the previous word plus round-half-up((KP_Q·(e−ePrev) + KI_DT_Q·(e+ePrev)) / 2^GAIN_FRAC). Here e is the voltage error and ePrev the error stored at the previous strobe; both stored values are zero after reset.
- R4: The control word is clamped to the range 0 to PEAK−1, and the clamped value is the one stored for the next update. The gate is therefore never high for a whole carrier period, and it is low whenever the carrier is at its peak.
- R5: Without a strobe, changes on refSpeed and actSpeed change neither the control word nor the gate duty.
- R6: The carrier counts 0 up to PEAK and back down, with PEAK = CLK_HZ/(2·PWM_HZ), giving a period of 2·PEAK clocks. The gate is high one clock after each cycle in which the latched duty D exceeds the carrier. This gives 2·D−1 high clocks per period for D ≥ 1 and none for D = 0, and the gate rises once per period.
- R7: The duty used by the compare changes only at the carrier valley. A high pulse across a change from duty A to duty B (both ≥ 1) therefore lasts 2A−1, A+B−1 or 2B−1 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleStb | input | 1 | One-clock strobe that takes a control sample |
| refSpeed | input | SPD_W | Commanded speed, signed |
| actSpeed | input | SPD_W | Measured rotor speed, signed |
| gateOut | output | 1 | Gate signal for the converter switch |

## Verification
The bench builds the block with CLK_HZ set to 2 MHz, so PEAK is 50 and a carrier period is 100 clocks. Every duty value can then be read back as a high-count over a single period, and many samples fit in a short run. The gains and scale keep their default values, so the ratio of 41/256 and the gains of 2458/4096 and 20/4096 are exercised as delivered. A three-thousand-speed step drives the word into the upper clamp, and the next strobe shows whether the clamped value or an unclamped value was stored.

// File: rtl/spi_pkg.sv
package spi_pkg;
  // Strobes from the carrier/control section to the datapath.
  typedef struct packed {
    logic sample;  // take a new control sample
    logic valley;  // carrier is at zero: duty may be reloaded
  } ctrlStb_t;
endpackage

// File: rtl/spi_carrier_ctrl.sv
module spi_carrier_ctrl
  import spi_pkg::*;
#(
  parameter int PEAK  = 3125,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleStb,
  output logic [CNT_W-1:0] carrierCnt,
  output ctrlStb_t         stb
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(PEAK);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic countUp;

  always_ff @(posedge clk) begin
    if (rst) begin
      carrierCnt <= '0;
      countUp    <= 1'b1;
    end else if (countUp) begin
      carrierCnt <= carrierCnt + ONE;
      if (carrierCnt + ONE == TOP) countUp <= 1'b0;
    end else begin
      carrierCnt <= carrierCnt - ONE;
      if (carrierCnt - ONE == '0) countUp <= 1'b1;
    end
  end

  always_comb begin
    stb.sample = sampleStb;
    stb.valley = (carrierCnt == '0);
  end
endmodule

// File: rtl/spi_datapath.sv
module spi_datapath
  import spi_pkg::*;
#(
  parameter int SPD_W      = 16,
  parameter int SCALE_W    = 16,
  parameter int SCALE_FRAC = 8,
  parameter int SCALE_Q    = 41,
  parameter int GAIN_W     = 16,
  parameter int GAIN_FRAC  = 12,
  parameter int KP_Q       = 2458,
  parameter int KI_DT_Q    = 20,
  parameter int PEAK       = 3125,
  parameter int CNT_W      = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctrlStb_t                stb,
  input  logic signed [SPD_W-1:0] refSpeed,
  input  logic signed [SPD_W-1:0] actSpeed,
  input  logic [CNT_W-1:0]        carrierCnt,
  output logic [CNT_W-1:0]        ctrlWord,
  output logic [CNT_W-1:0]        dutyLatched,
  output logic                    gateOut
);
  localparam int ERR_W = SPD_W + 1;
  localparam int VE_W  = ERR_W + SCALE_W + 1;
  localparam int ACC_W = VE_W + GAIN_W + 3;

  localparam logic signed [VE_W-1:0]  SCALE_X = VE_W'(SCALE_Q);
  localparam logic signed [VE_W-1:0]  VE_HALF = VE_W'(2 ** (SCALE_FRAC - 1));
  localparam logic signed [ACC_W-1:0] KP_X    = ACC_W'(KP_Q);
  localparam logic signed [ACC_W-1:0] KI_X    = ACC_W'(KI_DT_Q);
  localparam logic signed [ACC_W-1:0] G_HALF  = ACC_W'(2 ** (GAIN_FRAC - 1));
  localparam logic signed [ACC_W-1:0] U_MAX   = ACC_W'(PEAK - 1);

  logic signed [ERR_W-1:0] spdErr;
  logic signed [VE_W-1:0]  veProd, veNow, vePrev;
  logic signed [ACC_W-1:0] diffX, sumX, accX, deltaX, uPrevX, uNew, uClampWide;
  logic [CNT_W-1:0]        uClamp;

  // Speed error and its voltage equivalent (round half up).
  always_comb begin
    spdErr = ERR_W'(refSpeed) - ERR_W'(actSpeed);
    veProd = VE_W'(spdErr) * SCALE_X;
    veNow  = (veProd + VE_HALF) >>> SCALE_FRAC;
  end

  // Incremental PI with trapezoidal integral, then clamp.
  always_comb begin
    diffX  = ACC_W'(veNow) - ACC_W'(vePrev);
    sumX   = ACC_W'(veNow) + ACC_W'(vePrev);
    accX   = diffX * KP_X + sumX * KI_X;
    deltaX = (accX + G_HALF) >>> GAIN_FRAC;
    uPrevX = $signed(ACC_W'(ctrlWord));
    uNew   = uPrevX + deltaX;
    if (uNew < 0)          uClampWide = '0;
    else if (uNew > U_MAX) uClampWide = U_MAX;
    else                   uClampWide = uNew;
    uClamp = CNT_W'(uClampWide);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vePrev      <= '0;
      ctrlWord    <= '0;
      dutyLatched <= '0;
      gateOut     <= 1'b0;
    end else begin
      if (stb.sample) begin
        vePrev   <= veNow;
        ctrlWord <= uClamp;  // clamped value kept: no windup
      end
      if (stb.valley) dutyLatched <= ctrlWord;
      gateOut <= (dutyLatched > carrierCnt);
    end
  end
endmodule

// File: rtl/speed_pi_pwm.sv
module speed_pi_pwm
  import spi_pkg::*;
#(
  parameter int SPD_W      = 16,
  parameter int SCALE_W    = 16,
  parameter int SCALE_FRAC = 8,
  parameter int SCALE_Q    = 41,
  parameter int GAIN_W     = 16,
  parameter int GAIN_FRAC  = 12,
  parameter int KP_Q       = 2458,
  parameter int KI_DT_Q    = 20,
  parameter int CLK_HZ     = 125_000_000,
  parameter int PWM_HZ     = 20_000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sampleStb,
  input  logic signed [SPD_W-1:0] refSpeed,
  input  logic signed [SPD_W-1:0] actSpeed,
  output logic                    gateOut
);
  localparam int PEAK  = CLK_HZ / (2 * PWM_HZ);
  localparam int CNT_W = $clog2(PEAK + 1);

  ctrlStb_t         stb;
  logic [CNT_W-1:0] carrierCnt;
  logic [CNT_W-1:0] ctrlWord;
  logic [CNT_W-1:0] dutyLatched;

  spi_carrier_ctrl #(.PEAK(PEAK), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .sampleStb(sampleStb),
    .carrierCnt(carrierCnt), .stb(stb)
  );

  spi_datapath #(
    .SPD_W(SPD_W), .SCALE_W(SCALE_W), .SCALE_FRAC(SCALE_FRAC), .SCALE_Q(SCALE_Q),
    .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .KP_Q(KP_Q), .KI_DT_Q(KI_DT_Q),
    .PEAK(PEAK), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .refSpeed(refSpeed), .actSpeed(actSpeed),
    .carrierCnt(carrierCnt), .ctrlWord(ctrlWord), .dutyLatched(dutyLatched),
    .gateOut(gateOut)
  );
endmodule

// File: rtl/spi_checker.sv
module spi_checker #(
  parameter int PEAK  = 3125,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             sampleStb,
  input logic [CNT_W-1:0] carrierCnt,
  input logic [CNT_W-1:0] ctrlWord,
  input logic [CNT_W-1:0] dutyLatched,
  input logic             gateOut
);
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    !sampleStb |=> $stable(ctrlWord)); // R5

  AST_DUTY_AT_VALLEY: assert property (@(posedge clk) disable iff (rst)
    (carrierCnt != '0) |=> $stable(dutyLatched)); // R7

  AST_CARRIER_BOUND: assert property (@(posedge clk) disable iff (rst)
    carrierCnt <= CNT_W'(PEAK)); // R6

  AST_GATE_OFF_PEAK: assert property (@(posedge clk) disable iff (rst)
    (carrierCnt == CNT_W'(PEAK)) |-> !gateOut); // R4

  AST_WORD_CLAMPED: assert property (@(posedge clk) disable iff (rst)
    ctrlWord < CNT_W'(PEAK)); // R4
endmodule

bind speed_pi_pwm spi_checker #(.PEAK(PEAK), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sampleStb(sampleStb), .carrierCnt(carrierCnt),
  .ctrlWord(ctrlWord), .dutyLatched(dutyLatched), .gateOut(gateOut)
);

// File: tb/test_speed_pi_pwm.sv
module test_speed_pi_pwm;
  localparam int CLK_HZ = 2_000_000;
  localparam int PWM_HZ = 20_000;
  localparam int PEAK   = CLK_HZ / (2 * PWM_HZ);
  localparam int SF = 8, SCALE_Q = 41, GF = 12, KP = 2458, KI = 20;

  logic clk = 0, rst = 1, sampleStb = 0;
  logic signed [15:0] refSpeed = 0, actSpeed = 0;
  logic gateOut;

  int checks = 0, errors = 0;
  bit done = 0;
  longint vp = 0, up = 0, prevU = 0;

  always #4 clk = ~clk;

  speed_pi_pwm #(.CLK_HZ(CLK_HZ), .PWM_HZ(PWM_HZ)) i_speed_pi_pwm (
    .clk(clk), .rst(rst), .sampleStb(sampleStb),
    .refSpeed(refSpeed), .actSpeed(actSpeed), .gateOut(gateOut)
  );

  function automatic longint rnd(longint x, int f);
    return (x + (64'sd1 <<< (f - 1))) >>> f;
  endfunction

  function automatic int expHigh(longint d);
    return (d == 0) ? 0 : int'(2 * d - 1);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(int r, int a);
    longint e, ve, acc, u;
    @(negedge clk);
    refSpeed = 16'(r); actSpeed = 16'(a); sampleStb = 1;
    @(negedge clk);
    sampleStb = 0;
    e   = longint'(r) - longint'(a);
    ve  = rnd(e * SCALE_Q, SF);
    acc = KP * (ve - vp) + KI * (ve + vp);
    u   = up + rnd(acc, GF);
    if (u < 0) u = 0;
    if (u > PEAK - 1) u = PEAK - 1;
    prevU = up; vp = ve; up = u;
  endtask

  task automatic measure(output int hi);
    hi = 0;
    repeat (2 * PEAK) begin
      @(negedge clk);
      hi += int'(gateOut);
    end
  endtask

  // Follows pulses while the new duty settles; checks R7 pulse lengths.
  task automatic settleTrack();
    bit lowSeen = 0, inPulse = 0, valid = 0, ok = 1;
    int len = 0, bad = 0;
    longint a = prevU, b = up;
    repeat (2 * PEAK + 6) begin
      @(negedge clk);
      if (gateOut) begin
        if (!inPulse) begin inPulse = 1; valid = lowSeen; len = 0; end
        len++;
      end else begin
        if (inPulse && valid && a >= 1 && b >= 1) begin
          if (len != 2*a-1 && len != a+b-1 && len != 2*b-1) begin ok = 0; bad = len; end
        end
        inPulse = 0; lowSeen = 1;
      end
    end
    if (a >= 1 && b >= 1) check(ok, "R7 pulse length across duty change", bad, a + b - 1);
  endtask

  task automatic checkDuty(string req);
    int hi;
    measure(hi);
    check(hi == expHigh(up), req, hi, expHigh(up));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hi, t0, t1;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(gateOut == 0, "R1 gate low in reset", gateOut, 0);
    repeat (2) @(negedge clk);
    rst = 0;
    measure(hi);
    check(hi == 0, "R1 gate low after reset", hi, 0);

    // R2/R3: error 100 -> voltage error 16 -> word 10
    strobe(1000, 900); settleTrack();
    checkDuty("R2 R3 first step word 10");
    // R3: same error, integral alone too small to move the word
    strobe(1000, 900); settleTrack();
    checkDuty("R3 repeated error holds word");

    // R6: period from rise to rise
    @(negedge clk); while (gateOut) @(negedge clk);
    while (!gateOut) @(negedge clk);
    t0 = $time / 8;
    while (gateOut) @(negedge clk);
    while (!gateOut) @(negedge clk);
    t1 = $time / 8;
    check(t1 - t0 == 2 * PEAK, "R6 carrier period", t1 - t0, 2 * PEAK);

    // R4: large step saturates at PEAK-1
    strobe(3000, 0); settleTrack();
    checkDuty("R4 upper clamp");
    // R4 anti-windup: zero error pulls clamped word down to 0
    strobe(1000, 1000); settleTrack();
    checkDuty("R4 stored clamped value");
    strobe(0, 3000); settleTrack();
    checkDuty("R4 lower clamp");
    strobe(1100, 900); settleTrack();
    checkDuty("R3 recovery from zero");

    // R5: speeds move without strobe
    @(negedge clk); refSpeed = 16'sd3000; actSpeed = -16'sd3000;
    repeat (3 * PEAK) @(negedge clk);
    checkDuty("R5 no strobe no change");

    // Random samples (R2 R3 R4 R6 R7)
    for (int i = 0; i < 45; i++) begin
      int r, a;
      r = 800 + int'($urandom_range(0, 400));
      a = r - 150 + int'($urandom_range(0, 300));
      if ($urandom_range(0, 7) == 0) a = r + 2000 - int'($urandom_range(0, 4000));
      strobe(r, a); settleTrack();
      checkDuty("R3 R6 random sample duty");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule